// File: doc/BRIEF.md
# Partitioned Lane Compare with Shifted Mask

This block compares two 64-bit operands that are split into equal lanes of 8, 16 or 32 bits. Each lane produces one result bit, giving a mask of 8, 4 or 2 bits. The mask is moved left by a position operand scaled by its own width, and the block returns it as a 64-bit integer.

A sequence of such results can be OR-ed together to pack the masks of several compares into one register. Besides equality and ordered compares in signed and unsigned form, two special operations build the second operand per lane from one half of `src_b` repeated twice:

- **Dual-equal** matches a lane against either half of `src_b`.
- **Unsigned range** tests whether a lane lies between a lower bound taken from the upper half and an upper bound taken from the lower half.

The result is registered and appears one cycle after the request, with its own valid strobe.

Top module: `lane_cmp_shift`

## Requirements
- R1: While `rst` is high, and after it falls until the first accepted request, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `result` changes only in the cycle after an accepted request (`in_valid`=1). Otherwise it holds its value, whatever the other inputs do.
- R3: `lane_sel` selects the lane width: 0 gives 8-bit lanes (8 mask bits), 1 gives 16-bit lanes (4 mask bits), 2 and 3 give 32-bit lanes (2 mask bits). Lane i occupies bits [i*W+W-1 : i*W] of each operand and drives unshifted mask bit i.
- R4: `op_sel`=0 sets a lane's bit when the `src_a` lane equals the `src_b` lane. `op_sel`=1 sets it when they differ.
- R5: `op_sel`=2 sets the bit when the `src_a` lane is greater than the `src_b` lane as two's complement numbers. `op_sel`=3 sets it when it is less or equal under the same rule.
- R6: `op_sel`=4 and `op_sel`=5 are the greater-than and less-or-equal tests with both lanes read as unsigned numbers.
- R7: `op_sel`=6 (dual-equal) sets a lane's bit when the `src_a` lane equals the same lane of {`src_b[63:32]`,`src_b[63:32]`} or of {`src_b[31:0]`,`src_b[31:0]`}.
- R8: `op_sel`=7 (unsigned range) sets a lane's bit when LB <= x <= HB, unsigned. Here x is the `src_a` lane, LB is the same lane of {`src_b[63:32]`,`src_b[63:32]`} and HB is the same lane of {`src_b[31:0]`,`src_b[31:0]`}.
- R9: The mask is shifted left by `shamt` times the mask width (8, 4 or 2). Vacated low bits are 0, and bits moved past bit 63 are lost. A shift of 64 or more yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_a | input | 64 | First partitioned operand |
| src_b | input | 64 | Second partitioned operand, or the pair of halves used for bounds and match values |
| lane_sel | input | 2 | Lane width select |
| op_sel | input | 3 | Compare operation select |
| shamt | input | 6 | Mask position operand, in units of mask width |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Shifted compare mask |

## Verification
The sweep covers every lane width, every operation and every shift value. Operand bytes are drawn mostly from 00, 7F, 80 and FF, so lanes often sit exactly on the sign boundary or on a range bound, and lanes often match.

- A design that swapped signed and unsigned ordering would fail lanes holding 7F against 80.
- A design with an exclusive range bound would drop lanes equal to a bound.
- A design that paired each lane with the wrong half of `src_b` would miss dual-equal matches, which the bench provokes by placing the swapped halves of `src_b` in `src_a`.

Large shift values catch a scaled shift that wraps instead of dropping bits. Idle cycles with changed inputs catch a result register that loads without a request.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

    localparam int unsigned DATA_W    = 64;
    localparam int unsigned HALF_W    = DATA_W / 2;
    localparam int unsigned MIN_LANE  = 8;
    localparam int unsigned MAX_LANES = DATA_W / MIN_LANE;
    localparam int unsigned NUM_WIDTHS = 3;

    typedef enum logic [1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_32X = 2'd3
    } lane_w_e;

    typedef enum logic [2:0] {
        OP_EQ   = 3'd0,
        OP_NE   = 3'd1,
        OP_SGT  = 3'd2,
        OP_SLE  = 3'd3,
        OP_UGT  = 3'd4,
        OP_ULE  = 3'd5,
        OP_DEQ  = 3'd6,
        OP_URNG = 3'd7
    } cmp_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        lane_w_e           lane;
        cmp_op_e           op;
    } cmp_req_t;

    // Index of the width bank (0: 8-bit, 1: 16-bit, 2: 32-bit)
    function automatic logic [1:0] bank_index(lane_w_e lw);
        return (lw == LW_32X) ? 2'd2 : 2'(lw);
    endfunction

    // Number of mask bits produced for a lane width
    function automatic logic [3:0] mask_width(lane_w_e lw);
        case (lw)
            LW_8:    return 4'd8;
            LW_16:   return 4'd4;
            default: return 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/pcmp_width_bank.sv
module pcmp_width_bank
    import pcmp_pkg::*;
#(
    parameter int unsigned LANE_W = 8
) (
    input  cmp_req_t              req,
    output logic [MAX_LANES-1:0]  mask
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] rep_hi;
    logic [DATA_W-1:0] rep_lo;

    assign rep_hi = {req.b[DATA_W-1:HALF_W], req.b[DATA_W-1:HALF_W]};
    assign rep_lo = {req.b[HALF_W-1:0], req.b[HALF_W-1:0]};

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            logic [LANE_W-1:0] x, y, lb, hb;
            logic eq_y, ugt_y, sgt_y, hit;

            assign x  = req.a[i*LANE_W +: LANE_W];
            assign y  = req.b[i*LANE_W +: LANE_W];
            assign lb = rep_hi[i*LANE_W +: LANE_W];
            assign hb = rep_lo[i*LANE_W +: LANE_W];

            assign eq_y  = (x == y);
            assign ugt_y = (x > y);
            assign sgt_y = ($signed(x) > $signed(y));

            always_comb begin
                case (req.op)
                    OP_EQ:   hit = eq_y;
                    OP_NE:   hit = !eq_y;
                    OP_SGT:  hit = sgt_y;
                    OP_SLE:  hit = !sgt_y;
                    OP_UGT:  hit = ugt_y;
                    OP_ULE:  hit = !ugt_y;
                    OP_DEQ:  hit = (x == lb) || (x == hb);
                    default: hit = (x >= lb) && (x <= hb);
                endcase
            end

            assign mask[i] = hit;
        end

        if (LANES < MAX_LANES) begin : g_pad
            assign mask[MAX_LANES-1:LANES] = '0;
        end
    endgenerate

endmodule

// File: rtl/pcmp_mask_shift.sv
module pcmp_mask_shift
    import pcmp_pkg::*;
#(
    parameter int unsigned SHIFT_W = 6
) (
    input  logic [MAX_LANES-1:0] mask,
    input  lane_w_e              lane,
    input  logic [SHIFT_W-1:0]   shamt,
    output logic [DATA_W-1:0]    shifted
);
    localparam int unsigned AMT_W = SHIFT_W + 4;

    logic [AMT_W-1:0]  amount;
    logic [DATA_W-1:0] wide;

    assign amount  = AMT_W'(shamt) * AMT_W'(mask_width(lane));
    assign wide    = DATA_W'(mask);
    assign shifted = (amount >= AMT_W'(DATA_W)) ? '0 : (wide << amount);

endmodule

// File: rtl/lane_cmp_shift.sv
module lane_cmp_shift
    import pcmp_pkg::*;
#(
    parameter int unsigned SHIFT_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [63:0]        src_a,
    input  logic [63:0]        src_b,
    input  logic [1:0]         lane_sel,
    input  logic [2:0]         op_sel,
    input  logic [SHIFT_W-1:0] shamt,
    output logic               out_valid,
    output logic [63:0]        result
);
    cmp_req_t              req;
    logic [MAX_LANES-1:0]  bank_mask [NUM_WIDTHS];
    logic [MAX_LANES-1:0]  sel_mask;
    logic [DATA_W-1:0]     shifted;

    assign req.a    = src_a;
    assign req.b    = src_b;
    assign req.lane = lane_w_e'(lane_sel);
    assign req.op   = cmp_op_e'(op_sel);

    genvar k;
    generate
        for (k = 0; k < NUM_WIDTHS; k++) begin : g_bank
            pcmp_width_bank #(.LANE_W(MIN_LANE << k)) u_bank (
                .req  (req),
                .mask (bank_mask[k])
            );
        end
    endgenerate

    assign sel_mask = bank_mask[bank_index(req.lane)];

    pcmp_mask_shift #(.SHIFT_W(SHIFT_W)) u_shift (
        .mask    (sel_mask),
        .lane    (req.lane),
        .shamt   (shamt),
        .shifted (shifted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= shifted;
            end
        end
    end

endmodule

// File: rtl/pcmp_checker.sv
module pcmp_checker
    import pcmp_pkg::*;
#(
    parameter int unsigned SHIFT_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [63:0]        src_a,
    input logic [63:0]        src_b,
    input logic [1:0]         lane_sel,
    input logic [2:0]         op_sel,
    input logic [SHIFT_W-1:0] shamt,
    input logic               out_valid,
    input logic [63:0]        result
);
    localparam int unsigned AMT_W = SHIFT_W + 4;

    logic [AMT_W-1:0] s_amt;
    logic [3:0]       s_lanes;
    logic             s_same;
    logic [2:0]       s_op;

    always_ff @(posedge clk) begin
        s_amt   <= AMT_W'(shamt) * AMT_W'(mask_width(lane_w_e'(lane_sel)));
        s_lanes <= mask_width(lane_w_e'(lane_sel));
        s_same  <= (src_a == src_b);
        s_op    <= op_sel;
    end

    logic [63:0] low_keep;
    logic [63:0] full_mask;
    assign low_keep  = (s_amt >= AMT_W'(64)) ? {64{1'b1}} : ((64'd1 << s_amt) - 64'd1);
    assign full_mask = (s_amt >= AMT_W'(64)) ? 64'd0
                     : ((64'd1 << s_lanes) - 64'd1) << s_amt;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R2
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                        // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));                                   // R2
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((result & low_keep) == 64'd0));                     // R9
    AST_MASK_BITS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ($countones(result) <= int'(s_lanes)));              // R3
    AST_EQ_SELF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0 && src_a == src_b) |=> (result == full_mask)); // R4
    AST_NE_SELF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd1 && src_a == src_b) |=> (result == 64'd0));     // R4

    always_ff @(posedge clk) begin
        if (!rst && out_valid && s_same && s_op == 3'd3) begin
            AST_SLE_SELF: assert (result == full_mask);                   // R5
        end
    end

endmodule

bind lane_cmp_shift pcmp_checker #(.SHIFT_W(SHIFT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .lane_sel  (lane_sel),
    .op_sel    (op_sel),
    .shamt     (shamt),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_lane_cmp_shift.sv
`timescale 1ns/1ps
module sim_lane_cmp_shift;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [1:0]  lane_sel = '0;
    logic [2:0]  op_sel = '0;
    logic [5:0]  shamt = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lane_cmp_shift u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .lane_sel(lane_sel), .op_sel(op_sel), .shamt(shamt),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          int ls, int op, int sh);
        int w = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
        int n = 64 / w;
        logic [63:0] lm = (64'd1 << w) - 64'd1;
        logic [63:0] sb = 64'd1 << (w - 1);
        logic [63:0] hh = {b[63:32], b[63:32]};
        logic [63:0] ll = {b[31:0], b[31:0]};
        logic [63:0] m = '0;
        int amt;
        for (int i = 0; i < n; i++) begin
            logic [63:0] x = (a  >> (i*w)) & lm;
            logic [63:0] y = (b  >> (i*w)) & lm;
            logic [63:0] h = (hh >> (i*w)) & lm;
            logic [63:0] l = (ll >> (i*w)) & lm;
            bit r;
            case (op)
                0: r = (x == y);
                1: r = (x != y);
                2: r = ((x ^ sb) >  (y ^ sb));
                3: r = ((x ^ sb) <= (y ^ sb));
                4: r = (x > y);
                5: r = (x <= y);
                6: r = (x == h) || (x == l);
                default: r = (x >= h) && (x <= l);
            endcase
            m[i] = r;
        end
        amt = sh * n;
        if (amt >= 64) return 64'd0;
        return m << amt;
    endfunction

    function automatic string req_tag(int op);
        case (op)
            0, 1: return "R4";
            2, 3: return "R5";
            4, 5: return "R6";
            6:    return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [63:0] pick64();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) begin
            case ($urandom % 5)
                0: v[i*8 +: 8] = 8'h00;
                1: v[i*8 +: 8] = 8'h7F;
                2: v[i*8 +: 8] = 8'h80;
                3: v[i*8 +: 8] = 8'hFF;
                default: v[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request, then one idle cycle with altered inputs
    task automatic run_one(logic [63:0] a, logic [63:0] b, int ls, int op, int sh);
        logic [63:0] exp = model(a, b, ls, op, sh);
        @(negedge clk);
        src_a = a; src_b = b; lane_sel = 2'(ls); op_sel = 3'(op); shamt = 6'(sh);
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b1, "R2 valid", 64'(out_valid), 64'd1);
        check(result == exp, {req_tag(op), "/R3/R9 result"}, result, exp);
        in_valid = 1'b0;
        src_a = ~a; src_b = ~b; shamt = 6'(sh + 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle valid", 64'(out_valid), 64'd0);
        check(result == exp, "R2 hold", result, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", 64'(out_valid), 64'd0);
        check(result == 64'd0, "R1 result", result, 64'd0);
        rst = 1'b0;
        src_a = 64'hFFFF; op_sel = 3'd0;
        @(negedge clk);
        check(out_valid == 1'b0 && result == 64'd0, "R1 after release", result, 64'd0);

        for (int ls = 0; ls < 4; ls++) begin
            for (int op = 0; op < 8; op++) begin
                for (int sh = 0; sh < 64; sh++) begin
                    logic [63:0] b = pick64();
                    logic [63:0] a = pick64();
                    run_one(a, b, ls, op, sh);
                    // halves of b swapped into a: lanes meet match values and bounds
                    run_one({b[31:0], b[63:32]} ^ ((sh % 3 == 0) ? 64'd1 : 64'd0), b, ls, op, sh);
                end
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule